// File: doc/BRIEF.md
# SDRAM Refresh Scheduler with Credit

This block decides when an SDR SDRAM controller spends a slot on refresh. A down-counter runs from a refresh interval held in a register. Software writes that register at run time, typically once after start-up to match the density of the fitted memory. At 50 MHz, 390 cycles gives 7.8 µs and 780 cycles gives 15.6 µs. Each time the counter expires, the block owes one refresh. An external strobe can also demand a single refresh, so a timer outside the block can set the rate instead.

The block keeps the balance in a signed credit count. When the memory has no demand traffic, it refreshes ahead of time and builds up credit. While demand traffic is running, it holds refreshes back and lets the credit drain. It only insists on a refresh when the credit reaches its lower limit. The command sequencer receives requests through a request/grant handshake. A mode input selects what each refresh is: an auto-refresh command, or an activate/read of a row address that the block steps through itself.

Top module: `rfs_scheduler`

## Requirements
- R1: While reset is held and right after it, the outputs are: credit 0, row 0, no request. The interval register resets to 390 cycles, so the first credit decrement comes on the 390th clock edge after reset is released.
- R2: The interval counter expires once every `interval` clock edges. Each expiry lowers the credit by 1.
- R3: A write on `cfg_we` loads a new interval and restarts the count. The next expiry comes exactly `interval` edges after the write edge.
- R4: With `demand_busy` low, the block requests a refresh whenever the credit is below +8. Each granted refresh raises the credit by 1. At +8, no request is raised.
- R5: With `demand_busy` high, no request is raised while the credit is above -8 and no external request is pending. The credit keeps draining.
- R6: When the credit is -8, a request is raised on the next edge, even during demand traffic. `ref_urgent` is high while that request waits.
- R7: A one-cycle pulse on `ext_req` causes exactly one refresh request, even when the credit is +8 and demand is busy. The credit saturates at +8 when that refresh is granted.
- R8: Once `ref_req` is raised, it stays high, with `ref_kind` and `ref_row` unchanged, until a cycle in which `ref_gnt` is high. Credit and row change only on a granted cycle (apart from interval expiry for the credit).
- R9: `ref_kind` is 0 for an auto-refresh and 1 for a row read. It is captured from `mode_row_read` when the request is raised. `ref_row` advances by 1 only when a row-read refresh is granted.
- R10: The row counter counts 0 to ROWS-1 (4096 by default) and then wraps to 0.
- R11: The credit never goes below -8. An expiry at -8 leaves it at -8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load `cfg_interval` into the interval register |
| cfg_interval | input | 16 | Refresh interval in clock cycles (at least 1) |
| mode_row_read | input | 1 | 1 selects row-read refresh, 0 selects auto-refresh |
| ext_req | input | 1 | Strobe that forces one refresh |
| demand_busy | input | 1 | Demand traffic is active |
| ref_gnt | input | 1 | Sequencer accepts the pending request |
| ref_req | output | 1 | Refresh request, held until granted |
| ref_urgent | output | 1 | Pending request must go ahead of demand accesses |
| ref_kind | output | 1 | 0 auto-refresh, 1 activate/read of `ref_row` |
| ref_row | output | 12 | Row address for a row-read refresh |
| credit | output | 5 | Signed refresh credit, -8 to +8 |

## Verification
All outputs come from registers. A grant therefore shows its effect on credit, row and request one edge later. A request needs one edge after its cause becomes visible in state: the credit reaching -8, or the pending flag set by `ext_req`. So an external strobe shows up as a request two edges after it is driven. Interval expiry is checked by counting edges from reset release, or from the configuration write edge, up to the exact edge where the credit drops. The bench drives and samples only on falling edges, and each check sits on the falling edge that follows the rising edge where its result is due.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    typedef enum logic {
        KIND_AUTO = 1'b0,
        KIND_ROW  = 1'b1
    } ref_kind_e;
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int IW  = 16,
    parameter int DEF = 390
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_val,
    output logic          tick
);
    typedef struct packed {
        logic [IW-1:0] interval;
        logic [IW-1:0] cnt;
    } tmr_t;

    localparam logic [IW-1:0] DEF_V = IW'(DEF);

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick  = 1'b0;
        if (cfg_we) begin
            tmr_d.interval = cfg_val;
            tmr_d.cnt      = cfg_val - 1'b1;
        end else if (tmr_q.cnt == '0) begin
            tick      = 1'b1;
            tmr_d.cnt = tmr_q.interval - 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.interval <= DEF_V;
            tmr_q.cnt      <= DEF_V - 1'b1;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.interval != '0) |-> (tmr_q.cnt < tmr_q.interval));
endmodule

// File: rtl/rfs_credit.sv
module rfs_credit #(
    parameter int LIMIT = 8,
    localparam int CW   = $clog2(LIMIT) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 hs,
    output logic signed [CW-1:0] credit,
    output logic                 at_floor,
    output logic                 at_ceil
);
    localparam logic signed [CW:0]   HI   = (CW+1)'(LIMIT);
    localparam logic signed [CW:0]   LO   = -HI;
    localparam logic signed [CW-1:0] HI_N = CW'(LIMIT);
    localparam logic signed [CW-1:0] LO_N = -HI_N;

    logic signed [CW-1:0] credit_d, credit_q;
    logic signed [CW:0]   sum;

    always_comb begin
        sum = $signed({credit_q[CW-1], credit_q})
            + $signed({{CW{1'b0}}, hs})
            - $signed({{CW{1'b0}}, tick});
        if (sum > HI)
            credit_d = HI_N;
        else if (sum < LO)
            credit_d = LO_N;
        else
            credit_d = sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) credit_q <= '0;
        else        credit_q <= credit_d;
    end

    assign credit   = credit_q;
    assign at_floor = (credit_q == LO_N);
    assign at_ceil  = (credit_q == HI_N);

    // R11
    credit_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_q >= LO_N) && (credit_q <= HI_N));
    // R8
    credit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs && !tick) |=> $stable(credit_q));
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
    parameter int ROWS = 4096,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [RW-1:0] row
);
    localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

    logic [RW-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (adv) row_d = (row_q == LAST) ? '0 : row_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;

    // R10
    row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && row_q == LAST) |=> (row_q == '0));
endmodule

// File: rtl/rfs_scheduler.sv
module rfs_scheduler
    import rfs_pkg::*;
#(
    parameter int IW    = 16,
    parameter int DEF   = 390,
    parameter int LIMIT = 8,
    parameter int ROWS  = 4096,
    localparam int CW   = $clog2(LIMIT) + 2,
    localparam int RW   = $clog2(ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IW-1:0]        cfg_interval,
    input  logic                 mode_row_read,
    input  logic                 ext_req,
    input  logic                 demand_busy,
    input  logic                 ref_gnt,
    output logic                 ref_req,
    output logic                 ref_urgent,
    output logic                 ref_kind,
    output logic [RW-1:0]        ref_row,
    output logic signed [CW-1:0] credit
);
    typedef struct packed {
        logic      req;
        ref_kind_e kind;
        logic      ext_pend;
    } sch_t;

    sch_t sch_d, sch_q;
    logic tick, hs, want, at_floor, at_ceil;

    assign hs = sch_q.req & ref_gnt;

    rfs_interval_timer #(.IW(IW), .DEF(DEF)) u_tmr (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_val(cfg_interval), .tick(tick)
    );

    rfs_credit #(.LIMIT(LIMIT)) u_crd (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hs(hs),
        .credit(credit), .at_floor(at_floor), .at_ceil(at_ceil)
    );

    rfs_row_ctr #(.ROWS(ROWS)) u_row (
        .clk(clk), .rst_n(rst_n), .adv(hs && sch_q.kind == KIND_ROW), .row(ref_row)
    );

    always_comb begin
        sch_d = sch_q;
        want  = sch_q.ext_pend | at_floor | (!demand_busy & !at_ceil);
        if (ext_req)
            sch_d.ext_pend = 1'b1;
        else if (hs)
            sch_d.ext_pend = 1'b0;
        if (hs) begin
            sch_d.req = 1'b0;
        end else if (!sch_q.req && want) begin
            sch_d.req  = 1'b1;
            sch_d.kind = mode_row_read ? KIND_ROW : KIND_AUTO;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sch_q.req      <= 1'b0;
            sch_q.kind     <= KIND_AUTO;
            sch_q.ext_pend <= 1'b0;
        end else begin
            sch_q <= sch_d;
        end
    end

    assign ref_req    = sch_q.req;
    assign ref_kind   = sch_q.kind;
    assign ref_urgent = sch_q.req & at_floor;

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt) |=> (ref_req && $stable(ref_kind) && $stable(ref_row)));
    // R6
    floor_raises_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_floor && !ref_req) |=> ref_req);
    // R4
    no_req_at_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_ceil && !ref_req && !sch_q.ext_pend) |=> !ref_req);
endmodule

// File: tb/rfs_scheduler_tb.sv
module rfs_scheduler_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [15:0]       cfg_interval = '0;
    logic              mode_row_read = 1'b0;
    logic              ext_req = 1'b0;
    logic              demand_busy = 1'b1;
    logic              ref_gnt = 1'b0;
    logic              ref_req, ref_urgent, ref_kind;
    logic [11:0]       ref_row;
    logic signed [4:0] credit;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    rfs_scheduler u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_interval(cfg_interval),
        .mode_row_read(mode_row_read), .ext_req(ext_req), .demand_busy(demand_busy),
        .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_urgent(ref_urgent),
        .ref_kind(ref_kind), .ref_row(ref_row), .credit(credit)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic write_interval(input int v);
        cfg_interval = 16'(v);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // returns edges until credit differs from start
    task automatic edges_to_drop(input int limit, output int n);
        int start = credit;
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (credit != start) begin n = i; break; end
        end
    endtask

    task automatic t_reset_and_interval();
        int n;
        repeat (3) @(negedge clk);
        // R1
        chk(credit == 0 && ref_row == 0 && ref_req == 0, "R1 reset state", int'(credit), 0);
        rst_n = 1'b1;
        edges_to_drop(500, n);
        // R1 R2
        chk(n == 390, "R1 default interval edges", n, 390);
        chk(credit == -1, "R2 tick lowers credit", int'(credit), -1);
        // R5
        chk(ref_req == 0, "R5 no request while busy", int'(ref_req), 0);
    endtask

    task automatic t_runtime_interval();
        int n;
        write_interval(10);
        edges_to_drop(50, n);
        // R3
        chk(n == 10, "R3 new interval edges", n, 10);
        chk(credit == -2, "R3 credit after tick", int'(credit), -2);
    endtask

    task automatic t_urgent();
        for (int i = 0; i < 200 && credit != -8; i++) @(negedge clk);
        // R5
        chk(ref_req == 0, "R5 no request above floor", int'(ref_req), 0);
        @(negedge clk);
        // R6
        chk(ref_req == 1 && ref_urgent == 1, "R6 urgent request", int'(ref_urgent), 1);
        chk(ref_kind == 0, "R9 auto kind", int'(ref_kind), 0);
        repeat (25) @(negedge clk);
        // R11
        chk(credit == -8, "R11 floor saturation", int'(credit), -8);
        // R8
        chk(ref_req == 1, "R8 request held", int'(ref_req), 1);
    endtask

    task automatic t_grant_auto();
        write_interval(1000);
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        // R8
        chk(credit == -7, "R8 grant raises credit", int'(credit), -7);
        // R9
        chk(ref_row == 0, "R9 auto refresh keeps row", int'(ref_row), 0);
        chk(ref_req == 0, "R8 request drops after grant", int'(ref_req), 0);
        repeat (5) @(negedge clk);
        // R5
        chk(ref_req == 0 && credit == -7, "R5 busy holds back", int'(credit), -7);
    endtask

    task automatic t_idle_fill();
        mode_row_read = 1'b1;
        demand_busy = 1'b0;
        @(negedge clk);
        // R4 R9
        chk(ref_req == 1 && ref_kind == 1, "R9 row-read kind", int'(ref_kind), 1);
        ref_gnt = 1'b1;
        repeat (40) @(negedge clk);
        ref_gnt = 1'b0;
        // R4
        chk(credit == 8, "R4 credit fills to ceiling", int'(credit), 8);
        chk(ref_row == 15, "R9 row advanced per row read", int'(ref_row), 15);
        repeat (4) @(negedge clk);
        chk(ref_req == 0, "R4 no request at ceiling", int'(ref_req), 0);
        demand_busy = 1'b1;
    endtask

    task automatic ext_refresh(input string rq, input bit check_it);
        ext_req = 1'b1;
        @(negedge clk);
        ext_req = 1'b0;
        @(negedge clk);
        if (check_it) chk(ref_req == 1, rq, int'(ref_req), 1);
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
    endtask

    task automatic t_external();
        ext_refresh("R7 external request raised", 1'b1);
        // R7
        chk(credit == 8, "R7 credit stays at ceiling", int'(credit), 8);
        chk(ref_row == 16, "R7 row read done", int'(ref_row), 16);
        repeat (4) @(negedge clk);
        chk(ref_req == 0, "R7 single refresh only", int'(ref_req), 0);
        mode_row_read = 1'b0;
        ext_refresh("R9 external auto request", 1'b1);
        chk(ref_row == 16, "R9 auto keeps row", int'(ref_row), 16);
    endtask

    task automatic t_wrap();
        mode_row_read = 1'b1;
        write_interval(60000);
        for (int i = 0; i < 4079; i++) ext_refresh("R10 walk", 1'b0);
        // R10
        chk(ref_row == 4095, "R10 last row", int'(ref_row), 4095);
        ext_refresh("R10 final request", 1'b1);
        chk(ref_row == 0, "R10 row wraps", int'(ref_row), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_and_interval();
        t_runtime_interval();
        t_urgent();
        t_grant_auto();
        t_idle_fill();
        t_external();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule